// File: doc/BRIEF.md
# Masked Multi-Lane Vector Execution Unit

This block carries out a single elementwise integer vector instruction over a programmable count of elements. Operands come from a small vector register file inside the unit, and results go back to it. The element count is set per instruction and is limited to the register length. Elements are dealt out round-robin to a set of identical pipelined lanes, so each lane takes every fourth element when there are four lanes. All the lanes issue in the same cycle. One group of elements leaves the issue stage per clock.

There are four operations: add, subtract, multiply, and a not-equal compare. Each one takes either two vector registers, or one broadcast scalar and one vector register. The compare writes a one-bit-per-element mask instead of a vector register. An arithmetic instruction can be predicated by that mask, so only the selected elements change. A host loads and reads registers through a side port while the unit is idle. It launches an instruction with a start pulse and waits for a one-cycle done pulse.

Top module: `vlane_exec`

## Requirements
- R1: Opcode 0 (add) writes `vd[i] = src_a[i] + vb[i]` modulo 2^32 for every element i below the effective length.
- R2: Opcode 1 (subtract) writes `vd[i] = src_a[i] - vb[i]` modulo 2^32.
- R3: Opcode 2 (multiply) writes the low 32 bits of the product `src_a[i] * vb[i]`.
- R4: When `use_scalar` is 1, `src_a` is the `scalar` input for every element. When it is 0, `src_a` is register `va`.
- R5: Opcode 3 (compare) sets mask bit i to 1 exactly when `src_a[i] != vb[i]`, for i below the effective length. Mask bits at or above that length keep their values. No vector register changes.
- R6: With `masked` at 1, an arithmetic instruction writes element i only where mask bit i is 1. Every other destination element keeps its old value.
- R7: Elements at index equal to or above the effective length are never written.
- R8: An accepted start with a length of 0 writes nothing, and `done` is high in the very next cycle.
- R9: With the default 4 lanes and 6 pipeline stages, `done` rises exactly ceil(L/4)+7 cycles after the edge that accepts the start, where L is the effective length. `done` is high for one cycle.
- R10: A start is accepted only while `busy` is low. `busy` is high from the cycle after an accepted non-zero-length start until `done` rises. A start presented while `busy` is high has no effect.
- R11: The effective length is `vl` when `vl` is 64 or less, and 64 otherwise.
- R12: After reset, `busy` and `done` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an instruction (accepted only while idle) |
| op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 not-equal compare |
| vd | input | 2 | Destination register |
| va | input | 2 | First source register |
| vb | input | 2 | Second source register |
| scalar | input | 32 | Broadcast operand for the scalar form |
| use_scalar | input | 1 | Replace the first source by `scalar` |
| masked | input | 1 | Predicate arithmetic writes by the mask |
| vl | input | 7 | Requested element count |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Side-port write strobe |
| ld_reg | input | 2 | Side-port write register |
| ld_idx | input | 6 | Side-port write element |
| ld_data | input | 32 | Side-port write data |
| rd_reg | input | 2 | Side-port read register |
| rd_idx | input | 6 | Side-port read element |
| rd_data | output | 32 | Side-port read data (combinational) |
| mask_out | output | 64 | Current mask register |

## Verification
The bench uses the default parameters: 4 lanes, 64-element registers, 4 registers and a 6-stage lane pipeline. At these values the exact completion cycle count is predictable, both for full lengths and for lengths that leave the last lane group partly filled (37, 13, 22). Lengths above the register size exercise the clamp. A compare followed by masked arithmetic checks predication against a mask the unit wrote itself. A second start during a long instruction checks that a busy launch is dropped.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
  typedef enum logic [1:0] {
    VOP_ADD = 2'd0,
    VOP_SUB = 2'd1,
    VOP_MUL = 2'd2,
    VOP_CNE = 2'd3
  } vop_e;
endpackage

// File: rtl/vlane_vrf.sv
module vlane_vrf #(
  parameter int NVREG = 4,
  parameter int MVL   = 64,
  parameter int EW    = 32,
  parameter int NL    = 4,
  localparam int VRW  = $clog2(NVREG),
  localparam int IW   = $clog2(MVL)
) (
  input  logic           clk,
  input  logic [VRW-1:0] src_a_reg,
  input  logic [VRW-1:0] src_b_reg,
  input  logic [IW-1:0]  lane_idx [NL],
  output logic [EW-1:0]  lane_a   [NL],
  output logic [EW-1:0]  lane_b   [NL],
  input  logic [VRW-1:0] wb_reg,
  input  logic [NL-1:0]  wb_vec_en,
  input  logic [NL-1:0]  wb_mask_en,
  input  logic [IW-1:0]  wb_idx   [NL],
  input  logic [EW-1:0]  wb_data  [NL],
  input  logic           ext_we,
  input  logic [VRW-1:0] ext_wreg,
  input  logic [IW-1:0]  ext_widx,
  input  logic [EW-1:0]  ext_wdata,
  input  logic [VRW-1:0] ext_rreg,
  input  logic [IW-1:0]  ext_ridx,
  output logic [EW-1:0]  ext_rdata,
  output logic [MVL-1:0] mask_bits
);
  logic [EW-1:0]  mem [NVREG*MVL];
  logic [MVL-1:0] mask_q;

  for (genvar l = 0; l < NL; l++) begin : g_rd
    assign lane_a[l] = mem[{src_a_reg, lane_idx[l]}];
    assign lane_b[l] = mem[{src_b_reg, lane_idx[l]}];
  end

  assign ext_rdata = mem[{ext_rreg, ext_ridx}];
  assign mask_bits = mask_q;

  always_ff @(posedge clk) begin
    if (ext_we) mem[{ext_wreg, ext_widx}] <= ext_wdata;
    for (int l = 0; l < NL; l++) begin
      if (wb_vec_en[l]) mem[{wb_reg, wb_idx[l]}] <= wb_data[l];
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (wb_mask_en[l]) mask_q[wb_idx[l]] <= wb_data[l][0];
    end
  end
endmodule

// File: rtl/vlane_pipe.sv
module vlane_pipe
  import vlane_pkg::*;
#(
  parameter int EW  = 32,
  parameter int IW  = 6,
  parameter int LAT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  vop_e          in_op,
  input  logic [EW-1:0] in_a,
  input  logic [EW-1:0] in_b,
  input  logic          in_en,
  input  logic [IW-1:0] in_idx,
  input  logic          in_last,
  output logic          out_vec_we,
  output logic          out_mask_we,
  output logic [EW-1:0] out_data,
  output logic [IW-1:0] out_idx,
  output logic          out_last
);
  logic [LAT-1:0] vld_q, vwe_q, mwe_q, last_q;
  logic [EW-1:0]  dat_q [LAT];
  logic [IW-1:0]  idx_q [LAT];
  logic [EW-1:0]  res0;
  logic           vwe0, mwe0;

  always_comb begin
    unique case (in_op)
      VOP_ADD: res0 = in_a + in_b;
      VOP_SUB: res0 = in_a - in_b;
      VOP_MUL: res0 = in_a * in_b;
      default: res0 = {{(EW-1){1'b0}}, (in_a != in_b)};
    endcase
    vwe0 = in_vld && in_en && (in_op != VOP_CNE);
    mwe0 = in_vld && (in_op == VOP_CNE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      vwe_q  <= '0;
      mwe_q  <= '0;
      last_q <= '0;
    end else begin
      vld_q[0]  <= in_vld;
      vwe_q[0]  <= vwe0;
      mwe_q[0]  <= mwe0;
      last_q[0] <= in_last;
      for (int k = 1; k < LAT; k++) begin
        vld_q[k]  <= vld_q[k-1];
        vwe_q[k]  <= vwe_q[k-1];
        mwe_q[k]  <= mwe_q[k-1];
        last_q[k] <= last_q[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      dat_q[0] <= res0;
      idx_q[0] <= in_idx;
    end
    for (int k = 1; k < LAT; k++) begin
      if (vld_q[k-1]) begin
        dat_q[k] <= dat_q[k-1];
        idx_q[k] <= idx_q[k-1];
      end
    end
  end

  assign out_vec_we  = vwe_q[LAT-1];
  assign out_mask_we = mwe_q[LAT-1];
  assign out_data    = dat_q[LAT-1];
  assign out_idx     = idx_q[LAT-1];
  assign out_last    = last_q[LAT-1];
endmodule

// File: rtl/vlane_issue.sv
module vlane_issue
  import vlane_pkg::*;
#(
  parameter int NL    = 4,
  parameter int MVL   = 64,
  parameter int VRW   = 2,
  parameter int EW    = 32,
  localparam int VLW  = $clog2(MVL+1),
  localparam int GW   = $clog2(MVL/NL+1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     op,
  input  logic [VRW-1:0] vd,
  input  logic [VRW-1:0] va,
  input  logic [VRW-1:0] vb,
  input  logic [EW-1:0]  scalar,
  input  logic           use_scalar,
  input  logic           masked,
  input  logic [VLW-1:0] vl,
  input  logic           tail_last,
  output logic           busy,
  output logic           issuing,
  output logic [GW-1:0]  grp,
  output logic           last_grp,
  output logic           zero_go,
  output vop_e           op_q,
  output logic [VRW-1:0] vd_q,
  output logic [VRW-1:0] va_q,
  output logic [VRW-1:0] vb_q,
  output logic [EW-1:0]  scal_q,
  output logic           uses_q,
  output logic           masked_q,
  output logic [VLW-1:0] vl_q
);
  logic           busy_q, busy_n, iss_q, iss_n, accept, ld_instr;
  logic [GW-1:0]  grp_q, grp_n;
  logic [VLW-1:0] vl_eff, ngrp;

  always_comb begin
    accept   = start && !busy_q;
    vl_eff   = (vl > VLW'(MVL)) ? VLW'(MVL) : vl;
    ngrp     = (vl_q + VLW'(NL-1)) / VLW'(NL);
    last_grp = (VLW'(grp_q) == ngrp - VLW'(1));
    busy_n   = busy_q;
    iss_n    = iss_q;
    grp_n    = grp_q;
    ld_instr = 1'b0;
    if (iss_q) begin
      if (last_grp) iss_n = 1'b0;
      else          grp_n = grp_q + GW'(1);
    end
    if (tail_last) busy_n = 1'b0;
    if (accept && vl_eff != '0) begin
      busy_n   = 1'b1;
      iss_n    = 1'b1;
      grp_n    = '0;
      ld_instr = 1'b1;
    end
    zero_go = accept && (vl_eff == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      iss_q  <= 1'b0;
      grp_q  <= '0;
    end else begin
      busy_q <= busy_n;
      iss_q  <= iss_n;
      grp_q  <= grp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_instr) begin
      op_q     <= vop_e'(op);
      vd_q     <= vd;
      va_q     <= va;
      vb_q     <= vb;
      scal_q   <= scalar;
      uses_q   <= use_scalar;
      masked_q <= masked;
      vl_q     <= vl_eff;
    end
  end

  assign busy    = busy_q;
  assign issuing = iss_q;
  assign grp     = grp_q;
endmodule

// File: rtl/vlane_exec.sv
module vlane_exec
  import vlane_pkg::*;
#(
  parameter int NL    = 4,
  parameter int MVL   = 64,
  parameter int NVREG = 4,
  parameter int EW    = 32,
  parameter int LAT   = 6,
  localparam int VRW  = $clog2(NVREG),
  localparam int IW   = $clog2(MVL),
  localparam int VLW  = $clog2(MVL+1),
  localparam int GW   = $clog2(MVL/NL+1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     op,
  input  logic [VRW-1:0] vd,
  input  logic [VRW-1:0] va,
  input  logic [VRW-1:0] vb,
  input  logic [EW-1:0]  scalar,
  input  logic           use_scalar,
  input  logic           masked,
  input  logic [VLW-1:0] vl,
  output logic           busy,
  output logic           done,
  input  logic           ld_en,
  input  logic [VRW-1:0] ld_reg,
  input  logic [IW-1:0]  ld_idx,
  input  logic [EW-1:0]  ld_data,
  input  logic [VRW-1:0] rd_reg,
  input  logic [IW-1:0]  rd_idx,
  output logic [EW-1:0]  rd_data,
  output logic [MVL-1:0] mask_out
);
  logic           issuing, last_grp, zero_go, uses_q, masked_q, tail_last, done_q;
  logic [GW-1:0]  grp;
  vop_e           op_q;
  logic [VRW-1:0] vd_q, va_q, vb_q;
  logic [EW-1:0]  scal_q;
  logic [VLW-1:0] vl_q;
  logic [IW-1:0]  e_idx [NL];
  logic [EW-1:0]  src_a [NL];
  logic [EW-1:0]  src_b [NL];
  logic [NL-1:0]  wb_vwe, wb_mwe, wb_last, wb_act;
  logic [EW-1:0]  wb_dat [NL];
  logic [IW-1:0]  wb_idx [NL];
  logic [NL*IW-1:0] wb_idx_flat;

  vlane_issue #(.NL(NL), .MVL(MVL), .VRW(VRW), .EW(EW)) u_issue (
    .clk, .rst_n, .start, .op, .vd, .va, .vb, .scalar, .use_scalar, .masked, .vl,
    .tail_last, .busy, .issuing, .grp, .last_grp, .zero_go, .op_q, .vd_q, .va_q,
    .vb_q, .scal_q, .uses_q, .masked_q, .vl_q
  );

  vlane_vrf #(.NVREG(NVREG), .MVL(MVL), .EW(EW), .NL(NL)) u_vrf (
    .clk, .src_a_reg(va_q), .src_b_reg(vb_q), .lane_idx(e_idx), .lane_a(src_a),
    .lane_b(src_b), .wb_reg(vd_q), .wb_vec_en(wb_vwe), .wb_mask_en(wb_mwe),
    .wb_idx(wb_idx), .wb_data(wb_dat), .ext_we(ld_en), .ext_wreg(ld_reg),
    .ext_widx(ld_idx), .ext_wdata(ld_data), .ext_rreg(rd_reg), .ext_ridx(rd_idx),
    .ext_rdata(rd_data), .mask_bits(mask_out)
  );

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic in_rng, l_vld, l_en, l_last;
    logic [EW-1:0] l_a;
    assign e_idx[l] = IW'(int'(grp) * NL + l);
    assign in_rng   = (int'(grp) * NL + l) < int'(vl_q);
    assign l_vld    = issuing && in_rng;
    assign l_en     = !masked_q || mask_out[e_idx[l]];
    assign l_a      = uses_q ? scal_q : src_a[l];
    assign l_last   = (l == 0) && issuing && last_grp;

    vlane_pipe #(.EW(EW), .IW(IW), .LAT(LAT)) u_pipe (
      .clk, .rst_n, .in_vld(l_vld), .in_op(op_q), .in_a(l_a), .in_b(src_b[l]),
      .in_en(l_en), .in_idx(e_idx[l]), .in_last(l_last), .out_vec_we(wb_vwe[l]),
      .out_mask_we(wb_mwe[l]), .out_data(wb_dat[l]), .out_idx(wb_idx[l]),
      .out_last(wb_last[l])
    );
    assign wb_act[l] = wb_vwe[l] | wb_mwe[l];
    assign wb_idx_flat[l*IW +: IW] = wb_idx[l];
  end

  assign tail_last = |wb_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= zero_go || tail_last;
  end

  assign done = done_q;
endmodule

// File: rtl/vlane_exec_chk.sv
module vlane_exec_chk #(
  parameter int NL  = 4,
  parameter int IW  = 6,
  parameter int VLW = 7,
  parameter int MVL = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [VLW-1:0]   vl,
  input logic             busy,
  input logic             done,
  input logic             issuing,
  input logic [VLW-1:0]   vl_q,
  input logic [NL-1:0]    wb_act,
  input logic [NL*IW-1:0] wb_idx_flat
);
  // R9 / R10: completion is signalled only once the unit has gone idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);

  // R10: issue only happens inside a busy window
  p_issue_busy_r10: assert property (@(posedge clk) disable iff (!rst_n) issuing |-> busy);

  // R10: busy only rises after a start
  p_busy_cause_r10: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));

  // R8: a zero-length launch while idle completes on the next cycle
  p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vl == '0) |=> done);

  // R11: the latched length never exceeds the register size
  p_len_cap_r11: assert property (@(posedge clk) disable iff (!rst_n) busy |-> vl_q <= VLW'(MVL));

  // R7: no write-back reaches an element at or beyond the length
  for (genvar l = 0; l < NL; l++) begin : g_wb
    p_wb_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_act[l] |-> VLW'(wb_idx_flat[l*IW +: IW]) < vl_q);
  end
endmodule

bind vlane_exec vlane_exec_chk #(.NL(NL), .IW(IW), .VLW(VLW), .MVL(MVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .busy(busy), .done(done),
  .issuing(issuing), .vl_q(vl_q), .wb_act(wb_act), .wb_idx_flat(wb_idx_flat)
);

// File: tb/vlane_exec_bench.sv
module vlane_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, use_scalar, masked, busy, done, ld_en;
  logic [1:0]  op, vd, va, vb, ld_reg, rd_reg;
  logic [31:0] scalar, ld_data, rd_data;
  logic [6:0]  vl;
  logic [5:0]  ld_idx, rd_idx;
  logic [63:0] mask_out;

  logic [31:0] ref_v [4][64];
  logic [63:0] ref_m;
  bit          mask_known = 0;
  int          n_run = 0, n_fail = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  vlane_exec u_vlane_exec (
    .clk, .rst_n, .start, .op, .vd, .va, .vb, .scalar, .use_scalar, .masked, .vl,
    .busy, .done, .ld_en, .ld_reg, .ld_idx, .ld_data, .rd_reg, .rd_idx, .rd_data,
    .mask_out
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int r, input int i, input logic [31:0] v);
    ld_en = 1; ld_reg = 2'(r); ld_idx = 6'(i); ld_data = v;
    @(posedge clk); @(negedge clk);
    ld_en = 0;
    ref_v[r][i] = v;
  endtask

  task automatic fill(input int r, input logic [31:0] a, input logic [31:0] b);
    for (int i = 0; i < 64; i++) poke(r, i, a * 32'(i) + b);
  endtask

  task automatic check_reg(input int r, input string tag);
    bit ok = 1; logic [31:0] a = 0, e = 0;
    for (int i = 0; i < 64; i++) begin
      rd_reg = 2'(r); rd_idx = 6'(i); #0.1;
      if (ok && rd_data !== ref_v[r][i]) begin ok = 0; a = rd_data; e = ref_v[r][i]; end
    end
    check(ok, tag, {32'd0, a}, {32'd0, e});
  endtask

  task automatic ref_apply(input logic [1:0] o, input int d, input int a, input int b,
                           input logic [31:0] s, input bit us, input bit m, input int len);
    int veff = (len > 64) ? 64 : len;
    logic [63:0] nm = ref_m;
    for (int i = 0; i < veff; i++) begin
      logic [31:0] x = us ? s : ref_v[a][i];
      logic [31:0] y = ref_v[b][i];
      logic [31:0] r;
      case (o)
        2'd0: r = x + y;
        2'd1: r = x - y;
        2'd2: r = x * y;
        default: r = 0;
      endcase
      if (o == 2'd3) nm[i] = (x != y);
      else if (!m || ref_m[i]) ref_v[d][i] = r;
    end
    ref_m = nm;
  endtask

  task automatic launch(input logic [1:0] o, input int d, input int a, input int b,
                        input logic [31:0] s, input bit us, input bit m, input int len);
    start = 1; op = o; vd = 2'(d); va = 2'(a); vb = 2'(b);
    scalar = s; use_scalar = us; masked = m; vl = 7'(len);
  endtask

  task automatic run_op(input logic [1:0] o, input int d, input int a, input int b,
                        input logic [31:0] s, input bit us, input bit m, input int len,
                        input string tag);
    int veff = (len > 64) ? 64 : len;
    int exp_c = (veff == 0) ? 1 : (veff + 3) / 4 + 7;
    int cnt = 1;
    ref_apply(o, d, a, b, s, us, m, len);
    launch(o, d, a, b, s, us, m, len);
    @(posedge clk); @(negedge clk);
    start = 0;
    while (!done && cnt < 200) begin @(negedge clk); cnt++; end
    check(cnt == exp_c, "R9 latency", 64'(cnt), 64'(exp_c));
    @(negedge clk);
    check(done == 1'b0, "R9 single pulse", {63'd0, done}, 64'd0);
    check_reg(d, tag);
    if (mask_known) check(mask_out === ref_m, tag, mask_out, ref_m);
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R12 busy", {63'd0, busy}, 64'd0);
    check(done == 1'b0, "R12 done", {63'd0, done}, 64'd0);
  endtask

  task automatic t_arith;
    fill(0, 32'd3, 32'd1);
    fill(1, 32'hFFFF_FFF9, 32'd1000);
    fill(2, 32'd1, 32'h5000);
    fill(3, 32'd2, 32'h9000);
    run_op(2'd0, 2, 0, 1, 0, 0, 0, 64, "R1 add");
    run_op(2'd1, 3, 0, 1, 0, 0, 0, 37, "R2 R7 sub partial");
    fill(0, 32'h1F2E_3D4C, 32'h7FFF_FFF0);
    run_op(2'd2, 2, 0, 1, 0, 0, 0, 64, "R3 mul");
  endtask

  task automatic t_scalar;
    run_op(2'd1, 3, 0, 1, 32'h100, 1, 0, 13, "R4 scalar sub");
    run_op(2'd2, 2, 0, 1, 32'hFFFF_FFFD, 1, 0, 64, "R4 scalar mul");
  endtask

  task automatic t_compare;
    for (int i = 0; i < 64; i += 5) poke(1, i, ref_v[0][i]);
    run_op(2'd3, 2, 0, 1, 0, 0, 0, 64, "R5 compare full");
    mask_known = 1;
    check(mask_out === ref_m, "R5 mask full", mask_out, ref_m);
    for (int i = 1; i < 64; i += 3) poke(1, i, ref_v[0][i]);
    run_op(2'd3, 3, 0, 1, 0, 0, 0, 50, "R5 compare partial");
  endtask

  task automatic t_masked;
    run_op(2'd0, 3, 0, 1, 0, 0, 1, 64, "R6 masked add");
    run_op(2'd2, 2, 0, 1, 0, 0, 1, 22, "R6 R7 masked mul partial");
  endtask

  task automatic t_edges;
    run_op(2'd0, 2, 0, 1, 0, 0, 0, 0, "R8 zero length");
    run_op(2'd0, 3, 1, 2, 0, 0, 0, 100, "R11 clamped length");
  endtask

  task automatic t_busy;
    int cnt = 1;
    ref_apply(2'd0, 2, 1, 3, 0, 0, 0, 64);
    launch(2'd0, 2, 1, 3, 0, 0, 0, 64);
    @(posedge clk); @(negedge clk);
    check(busy == 1'b1, "R10 busy after start", {63'd0, busy}, 64'd1);
    launch(2'd1, 3, 0, 1, 0, 0, 0, 64);
    @(posedge clk); @(negedge clk);
    start = 0; cnt = 2;
    while (!done && cnt < 200) begin @(negedge clk); cnt++; end
    check(cnt == 23, "R10 R9 latency unaffected", 64'(cnt), 64'd23);
    check(busy == 1'b0, "R10 idle at done", {63'd0, busy}, 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R10 no second done", {63'd0, done}, 64'd0);
    check_reg(2, "R10 first op result");
    check_reg(3, "R10 ignored start left v3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; op = 0; vd = 0; va = 0; vb = 0; scalar = 0;
    use_scalar = 0; masked = 0; vl = 0; ld_en = 0; ld_reg = 0; ld_idx = 0;
    ld_data = 0; rd_reg = 0; rd_idx = 0; ref_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_arith;
    t_scalar;
    t_compare;
    t_masked;
    t_edges;
    t_busy;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule